// File: doc/BRIEF.md
# Dual-Lane Load Writeback Steering

This block sits between the read port of a data memory and a register file split into two compute lanes, X and Y, each holding eight 32-bit registers. A load presents a descriptor and up to four fetched 32-bit words. The descriptor carries the access size, the lanes the load targets, a flag saying whether a register group (pair or quad) is named, a numeric-type qualifier and a base register index. The block turns these into per-lane, per-register write enables and write data. It also gives the post-increment to apply to the address register.

Targeting both lanes does not divide the fetched words between the lanes. Each word is copied into the register with the same number in X and in Y. The one exception is a long load that names a single register in both lanes: it sends word 0 to X and word 1 to Y. All outputs are registered and appear one cycle after the read-data-valid strobe.

Top module: `lwb_steer`

## Requirements
- R1: A normal load (`accSize`=0, `grouped`=0) writes word 0 (rdData[31:0]) into register `baseReg` of every selected lane. `laneSel` bit 0 selects X and bit 1 selects Y.
- R2: A long load (`accSize`=1) with `grouped`=0 and `laneSel`=3 writes word 0 to register `baseReg` of X and word 1 (rdData[63:32]) to register `baseReg` of Y.
- R3: A long load with `grouped`=1 to a single lane writes word 0 to register `baseReg` and word 1 to register `baseReg`+1 of that lane.
- R4: A long load with `grouped`=1 and `laneSel`=3 writes word 0 to register `baseReg` of both lanes and word 1 to register `baseReg`+1 of both lanes.
- R5: A quad load (`accSize`=2, `grouped`=1) to a single lane writes word k (rdData[32k+31:32k]) into register `baseReg`+k of that lane, for k from 0 to 3.
- R6: A quad load with `laneSel`=3 writes word k into register `baseReg`+k of both X and Y.
- R7: `postInc` is 1 for normal, 2 for long and 4 for quad loads, and 0 for the reserved size 3.
- R8: A grouped long load with an odd `baseReg`, or a quad load with `baseReg` not a multiple of four, raises `errFlag` and enables no write.
- R9: `laneSel`=0, size 3, a grouped normal load, an ungrouped quad load, or an ungrouped long load aimed at a single lane each raise `errFlag` and enable no write.
- R10: `outValid` and all outputs follow `rdValid` by exactly one clock cycle. While `outValid` is low, every write enable and `errFlag` are 0.
- R11: `isFloat` has no effect. Enables, data and increment are the same for either value, and the words are passed through bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | Fetched words and descriptor are valid this cycle |
| accSize | input | 2 | 0 normal, 1 long, 2 quad, 3 reserved |
| laneSel | input | 2 | Bit 0 lane X, bit 1 lane Y |
| grouped | input | 1 | Descriptor names a register pair or quad |
| isFloat | input | 1 | Numeric-type qualifier, no effect on steering |
| baseReg | input | 3 | Base register index |
| rdData | input | 128 | Fetched words, word k in bits 32k+31:32k |
| outValid | output | 1 | Writeback outputs valid |
| wrEnX | output | 8 | Per-register write enables, lane X |
| wrEnY | output | 8 | Per-register write enables, lane Y |
| wrDataX | output | 256 | Write data, register r in bits 32r+31:32r, lane X |
| wrDataY | output | 256 | Write data, register r in bits 32r+31:32r, lane Y |
| postInc | output | 3 | Address post-increment |
| errFlag | output | 1 | Descriptor is illegal or misaligned, writes suppressed |

## Verification
The assertions assume that the descriptor inputs are never unknown and that `rdValid` is a single-cycle strobe qualifying them. The bench drives every input on the falling edge and always starts from known zeros. It separates loads with idle cycles, so every output sample belongs to one load. The group bound holds only for decodes flagged legal, and the bench covers illegal and misaligned descriptors on purpose to exercise that split.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
  parameter int WORD_W    = 32;
  parameter int NUM_REGS  = 8;
  parameter int MAX_WORDS = 4;
  parameter int INC_W     = 3;

  localparam int IDX_W = $clog2(NUM_REGS);
  localparam int SEL_W = $clog2(MAX_WORDS);
  localparam int BUS_W = WORD_W * MAX_WORDS;
  localparam int RF_W  = WORD_W * NUM_REGS;

  typedef enum logic [1:0] {
    SZ_NORMAL = 2'd0,
    SZ_LONG   = 2'd1,
    SZ_QUAD   = 2'd2,
    SZ_RSVD   = 2'd3
  } accSize_e;

  // strobes from decode control to the writeback datapath
  typedef struct packed {
    logic [NUM_REGS-1:0]            enX;
    logic [NUM_REGS-1:0]            enY;
    logic [NUM_REGS-1:0][SEL_W-1:0] selX;
    logic [NUM_REGS-1:0][SEL_W-1:0] selY;
    logic                           err;
    logic [INC_W-1:0]               inc;
  } steer_t;
endpackage

// File: rtl/lwb_ctrl.sv
module lwb_ctrl
  import lwb_pkg::*;
(
  input  logic [1:0]       accSize,
  input  logic [1:0]       laneSel,
  input  logic             grouped,
  input  logic [IDX_W-1:0] baseReg,
  output steer_t           steer
);
  logic laneX, laneY;
  logic errRaw;
  steer_t raw;

  assign laneX = laneSel[0];
  assign laneY = laneSel[1];

  always_comb begin
    raw    = '0;
    errRaw = 1'b0;
    unique case (accSize_e'(accSize))
      SZ_NORMAL: begin
        raw.inc = INC_W'(1);
        errRaw  = grouped;
        raw.enX[baseReg] = laneX;
        raw.enY[baseReg] = laneY;
      end
      SZ_LONG: begin
        raw.inc = INC_W'(2);
        if (grouped) begin
          errRaw = baseReg[0];
          for (int k = 0; k < 2; k++) begin
            raw.enX[IDX_W'(baseReg + IDX_W'(k))]  = laneX;
            raw.enY[IDX_W'(baseReg + IDX_W'(k))]  = laneY;
            raw.selX[IDX_W'(baseReg + IDX_W'(k))] = SEL_W'(k);
            raw.selY[IDX_W'(baseReg + IDX_W'(k))] = SEL_W'(k);
          end
        end else begin
          // one register named, both lanes: word 0 to X, word 1 to Y
          errRaw = (laneSel != 2'b11);
          raw.enX[baseReg]  = 1'b1;
          raw.enY[baseReg]  = 1'b1;
          raw.selY[baseReg] = SEL_W'(1);
        end
      end
      SZ_QUAD: begin
        raw.inc = INC_W'(4);
        errRaw  = !grouped || (baseReg[1:0] != 2'b00);
        for (int k = 0; k < 4; k++) begin
          raw.enX[IDX_W'(baseReg + IDX_W'(k))]  = laneX;
          raw.enY[IDX_W'(baseReg + IDX_W'(k))]  = laneY;
          raw.selX[IDX_W'(baseReg + IDX_W'(k))] = SEL_W'(k);
          raw.selY[IDX_W'(baseReg + IDX_W'(k))] = SEL_W'(k);
        end
      end
      default: begin
        raw.inc = '0;
        errRaw  = 1'b1;
      end
    endcase
    if (laneSel == 2'b00) errRaw = 1'b1;
  end

  always_comb begin
    steer     = raw;
    steer.err = errRaw;
    if (errRaw) begin
      steer.enX = '0;
      steer.enY = '0;
    end
  end

  // a legal decode never touches more than a quad group per lane
  always_comb begin
    if (!steer.err) begin
      assert_group_bound_R6: assert ($countones(steer.enX) <= 4 && $countones(steer.enY) <= 4)
        else $error("more than four registers enabled in one lane");
    end
  end
endmodule

// File: rtl/lwb_datapath.sv
module lwb_datapath
  import lwb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rdValid,
  input  steer_t                 steer,
  input  logic [BUS_W-1:0]       rdData,
  output logic                   outValid,
  output logic [NUM_REGS-1:0]    wrEnX,
  output logic [NUM_REGS-1:0]    wrEnY,
  output logic [RF_W-1:0]        wrDataX,
  output logic [RF_W-1:0]        wrDataY,
  output logic [INC_W-1:0]       postInc,
  output logic                   errFlag
);
  logic [MAX_WORDS-1:0][WORD_W-1:0] words;
  logic [NUM_REGS-1:0][WORD_W-1:0]  dataXQ, dataYQ;

  assign words = rdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      wrEnX    <= '0;
      wrEnY    <= '0;
      postInc  <= '0;
      errFlag  <= 1'b0;
    end else begin
      outValid <= rdValid;
      wrEnX    <= rdValid ? steer.enX : '0;
      wrEnY    <= rdValid ? steer.enY : '0;
      postInc  <= rdValid ? steer.inc : '0;
      errFlag  <= rdValid & steer.err;
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataXQ[r] <= '0;
        dataYQ[r] <= '0;
      end else if (rdValid) begin
        dataXQ[r] <= words[steer.selX[r]];
        dataYQ[r] <= words[steer.selY[r]];
      end
    end
  end

  assign wrDataX = dataXQ;
  assign wrDataY = dataYQ;

  assert_err_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (wrEnX == '0 && wrEnY == '0))
    else $error("write enabled alongside error");

  assert_valid_lag_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> outValid)
    else $error("outValid missing one cycle after rdValid");

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (wrEnX == '0 && wrEnY == '0 && !errFlag))
    else $error("activity without outValid");

  assert_inc_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !errFlag) |-> $onehot(postInc))
    else $error("legal load without a power-of-two increment");
endmodule

// File: rtl/lwb_steer.sv
module lwb_steer
  import lwb_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdValid,
  input  logic [1:0]          accSize,
  input  logic [1:0]          laneSel,
  input  logic                grouped,
  input  logic                isFloat,
  input  logic [IDX_W-1:0]    baseReg,
  input  logic [BUS_W-1:0]    rdData,
  output logic                outValid,
  output logic [NUM_REGS-1:0] wrEnX,
  output logic [NUM_REGS-1:0] wrEnY,
  output logic [RF_W-1:0]     wrDataX,
  output logic [RF_W-1:0]     wrDataY,
  output logic [INC_W-1:0]    postInc,
  output logic                errFlag
);
  steer_t steer;

  lwb_ctrl u_ctrl (
    .accSize (accSize),
    .laneSel (laneSel),
    .grouped (grouped),
    .baseReg (baseReg),
    .steer   (steer)
  );

  lwb_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .rdValid  (rdValid),
    .steer    (steer),
    .rdData   (rdData),
    .outValid (outValid),
    .wrEnX    (wrEnX),
    .wrEnY    (wrEnY),
    .wrDataX  (wrDataX),
    .wrDataY  (wrDataY),
    .postInc  (postInc),
    .errFlag  (errFlag)
  );

  // the type qualifier is carried only so it can be checked as known
  assert_qual_known_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !$isunknown(isFloat))
    else $error("qualifier unknown on a valid load");
endmodule

// File: tb/lwb_steer_bench.sv
module lwb_steer_bench;
  localparam int CLK_P = 10;

  logic         clk = 1'b0;
  logic         rstN;
  logic         rdValid;
  logic [1:0]   accSize;
  logic [1:0]   laneSel;
  logic         grouped;
  logic         isFloat;
  logic [2:0]   baseReg;
  logic [127:0] rdData;
  logic         outValid;
  logic [7:0]   wrEnX, wrEnY;
  logic [255:0] wrDataX, wrDataY;
  logic [2:0]   postInc;
  logic         errFlag;

  logic [7:0][31:0] dx, dy;
  assign dx = wrDataX;
  assign dy = wrDataY;

  int tests = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  lwb_steer u_lwb_steer (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .accSize(accSize),
    .laneSel(laneSel), .grouped(grouped), .isFloat(isFloat),
    .baseReg(baseReg), .rdData(rdData), .outValid(outValid),
    .wrEnX(wrEnX), .wrEnY(wrEnY), .wrDataX(wrDataX), .wrDataY(wrDataY),
    .postInc(postInc), .errFlag(errFlag)
  );

  logic [3:0][31:0] w;
  logic [7:0][31:0] ex, ey;

  task automatic fill(input logic [31:0] seed);
    for (int k = 0; k < 4; k++) w[k] = seed ^ (32'h1111_0000 * (k + 1)) ^ k;
    ex = '0;
    ey = '0;
  endtask

  // one load on a falling edge, outputs sampled on the next falling edge
  task automatic doLoad(input logic [1:0] sz, input logic [1:0] ln,
                        input logic grp, input logic [2:0] b, input logic flt);
    @(negedge clk);
    accSize = sz; laneSel = ln; grouped = grp; baseReg = b; isFloat = flt;
    rdData = w; rdValid = 1'b1;
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic checkOut(input string tag, input logic [7:0] eEnX, input logic [7:0] eEnY,
                          input logic eErr, input logic [2:0] eInc);
    logic bad;
    bad = 1'b0;
    tests++;
    if (outValid !== 1'b1 || wrEnX !== eEnX || wrEnY !== eEnY ||
        errFlag !== eErr || postInc !== eInc) bad = 1'b1;
    for (int r = 0; r < 8; r++) begin
      if (eEnX[r] && dx[r] !== ex[r]) bad = 1'b1;
      if (eEnY[r] && dy[r] !== ey[r]) bad = 1'b1;
    end
    if (bad) begin
      fails++;
      $display("FAIL %s: got v=%b enX=%b enY=%b err=%b inc=%0d dataX=%h dataY=%h; exp enX=%b enY=%b err=%b inc=%0d dataX=%h dataY=%h",
               tag, outValid, wrEnX, wrEnY, errFlag, postInc, wrDataX, wrDataY,
               eEnX, eEnY, eErr, eInc, ex, ey);
    end
    @(negedge clk);
  endtask

  task automatic testReset();
    tests++;
    if (outValid !== 1'b0 || wrEnX !== 8'h0 || wrEnY !== 8'h0 || errFlag !== 1'b0) begin
      fails++;
      $display("FAIL R10 reset: got v=%b enX=%b enY=%b err=%b; exp all zero",
               outValid, wrEnX, wrEnY, errFlag);
    end
  endtask

  task automatic testNormal();
    fill(32'hCAFE_0001);
    ex[5] = w[0]; ey[5] = w[0];
    doLoad(2'd0, 2'b11, 1'b0, 3'd5, 1'b0);
    checkOut("R1 normal both lanes", 8'b0010_0000, 8'b0010_0000, 1'b0, 3'd1);
    fill(32'h0BAD_0002);
    ey[2] = w[0];
    doLoad(2'd0, 2'b10, 1'b0, 3'd2, 1'b0);
    checkOut("R1 normal Y only", 8'h00, 8'b0000_0100, 1'b0, 3'd1);
  endtask

  task automatic testLongSingle();
    fill(32'h1234_5678);
    ex[1] = w[0]; ey[1] = w[1];
    doLoad(2'd1, 2'b11, 1'b0, 3'd1, 1'b0);
    checkOut("R2 long single both", 8'b0000_0010, 8'b0000_0010, 1'b0, 3'd2);
  endtask

  task automatic testLongPair();
    fill(32'h5555_AAAA);
    ey[4] = w[0]; ey[5] = w[1];
    doLoad(2'd1, 2'b10, 1'b1, 3'd4, 1'b0);
    checkOut("R3 long pair Y", 8'h00, 8'b0011_0000, 1'b0, 3'd2);
    fill(32'h7777_0101);
    ex[2] = w[0]; ex[3] = w[1]; ey[2] = w[0]; ey[3] = w[1];
    doLoad(2'd1, 2'b11, 1'b1, 3'd2, 1'b0);
    checkOut("R4 long pair both", 8'b0000_1100, 8'b0000_1100, 1'b0, 3'd2);
  endtask

  task automatic testQuad();
    fill(32'hDEAD_BEEF);
    for (int k = 0; k < 4; k++) ex[4 + k] = w[k];
    doLoad(2'd2, 2'b01, 1'b1, 3'd4, 1'b0);
    checkOut("R5 quad X", 8'hF0, 8'h00, 1'b0, 3'd4);
    fill(32'h0F0F_3C3C);
    for (int k = 0; k < 4; k++) begin ex[k] = w[k]; ey[k] = w[k]; end
    doLoad(2'd2, 2'b11, 1'b1, 3'd0, 1'b0);
    checkOut("R6 quad both", 8'h0F, 8'h0F, 1'b0, 3'd4);
  endtask

  task automatic testIncReserved();
    fill(32'h0);
    doLoad(2'd3, 2'b01, 1'b0, 3'd0, 1'b0);
    checkOut("R7 reserved size inc 0", 8'h00, 8'h00, 1'b1, 3'd0);
  endtask

  task automatic testMisaligned();
    fill(32'h1);
    doLoad(2'd1, 2'b01, 1'b1, 3'd3, 1'b0);
    checkOut("R8 odd pair base", 8'h00, 8'h00, 1'b1, 3'd2);
    fill(32'h2);
    doLoad(2'd2, 2'b11, 1'b1, 3'd2, 1'b0);
    checkOut("R8 quad base 2", 8'h00, 8'h00, 1'b1, 3'd4);
  endtask

  task automatic testIllegal();
    fill(32'h3);
    doLoad(2'd0, 2'b00, 1'b0, 3'd0, 1'b0);
    checkOut("R9 no lane", 8'h00, 8'h00, 1'b1, 3'd1);
    doLoad(2'd1, 2'b01, 1'b0, 3'd6, 1'b0);
    checkOut("R9 long single one lane", 8'h00, 8'h00, 1'b1, 3'd2);
    doLoad(2'd2, 2'b10, 1'b0, 3'd4, 1'b0);
    checkOut("R9 quad ungrouped", 8'h00, 8'h00, 1'b1, 3'd4);
    doLoad(2'd0, 2'b01, 1'b1, 3'd2, 1'b0);
    checkOut("R9 normal grouped", 8'h00, 8'h00, 1'b1, 3'd1);
  endtask

  task automatic testTiming();
    // rdValid low: next sample must show nothing
    @(negedge clk);
    tests++;
    if (outValid !== 1'b0 || wrEnX !== 8'h0 || wrEnY !== 8'h0 || errFlag !== 1'b0) begin
      fails++;
      $display("FAIL R10 idle: got v=%b enX=%b enY=%b err=%b; exp all zero",
               outValid, wrEnX, wrEnY, errFlag);
    end
  endtask

  task automatic testFloat();
    fill(32'hBF80_0000);
    for (int k = 0; k < 4; k++) begin ex[k] = w[k]; ey[k] = w[k]; end
    doLoad(2'd2, 2'b11, 1'b1, 3'd0, 1'b1);
    checkOut("R11 float quad both", 8'h0F, 8'h0F, 1'b0, 3'd4);
    fill(32'h8000_0001);
    ex[7] = w[0]; ey[7] = w[1];
    doLoad(2'd1, 2'b11, 1'b0, 3'd7, 1'b1);
    checkOut("R11 float long single", 8'h80, 8'h80, 1'b0, 3'd2);
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; rdValid = 1'b0; accSize = '0; laneSel = '0;
    grouped = 1'b0; isFloat = 1'b0; baseReg = '0; rdData = '0;
    w = '0; ex = '0; ey = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNormal();
    testLongSingle();
    testLongPair();
    testQuad();
    testIncReserved();
    testMisaligned();
    testIllegal();
    testTiming();
    testFloat();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule